// File: doc/BRIEF.md
# Vector XOR Write Path with Upper-Lane Control

This block is the execute-and-writeback slice for a bitwise exclusive-or on a 256-bit vector register file of 16 entries. A valid strobe delivers one operation per cycle: a two-bit form code, a destination index, two source indices and an optional 256-bit memory operand that can replace the second register source. The result is captured into a staging register on the edge that accepts the operation and is written into the file on the following edge. A forwarding path makes the staged value visible to both read ports as soon as it is captured, so a dependent operation can issue in the very next cycle.

Three forms differ in how the upper 128 bits are treated. The destructive narrow form XORs the destination with the source and keeps the destination's upper half. The non-destructive narrow form XORs two sources and clears the upper half. The wide form XORs all 256 bits. The fourth form code is reserved: it raises a one-cycle fault and writes nothing. A small state machine tracks the writeback stage with three states: `ST_IDLE` (nothing staged), `ST_COMMIT` (a result staged, written on the next edge) and `ST_FAULT` (a reserved code was seen). From any state an accepted operation goes to `ST_COMMIT`, a reserved code goes to `ST_FAULT`, and no strobe goes to `ST_IDLE`.

Top module: `simd_xor_wpath`

## Requirements
- R1: With form code 2 (wide), the destination receives src1 XOR src2 over all 256 bits; each bit is 1 exactly when the two source bits differ.
- R2: With form code 1 (non-destructive narrow), bits 127:0 of the destination receive src1 XOR src2 and bits 255:128 become zero.
- R3: With form code 0 (destructive narrow), bits 127:0 of the destination receive destination XOR src2, bits 255:128 keep their old value, and the src1 index is not used.
- R4: When the memory-select input is 1, the memory operand replaces src2 in every form (only its low 128 bits matter in the narrow forms).
- R5: In form code 0 with the long-mode input at 0, bit 3 of the destination and src2 indices is ignored (registers 0 to 7 only); with long-mode at 1 bit 3 selects registers 8 to 15. The other forms always use all four index bits.
- R6: The cycle after an accepted operation, the write-valid output is 1 and the write-index output shows the effective destination.
- R7: A read of the destination register in the cycle after the operation already returns the new value, and the value is held in the file afterwards.
- R8: Form code 3 makes the fault output 1 for the next cycle, keeps write-valid at 0 and changes no register.
- R9: Reset clears all 16 registers, write-valid and fault.
- R10: A cycle with the valid strobe at 0 writes nothing and leaves write-valid and fault at 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_form | input | 2 | Form code: 0 destructive narrow, 1 narrow, 2 wide, 3 reserved |
| long_mode | input | 1 | Enables index bit 3 for form code 0 |
| dst_idx | input | 4 | Destination register index |
| src1_idx | input | 4 | First source index (read port A, wide and non-destructive forms) |
| src2_idx | input | 4 | Second source index (read port B) |
| use_mem | input | 1 | Selects the memory operand in place of src2 |
| mem_data | input | 256 | Memory operand |
| rda_data | output | 256 | Read port A value, forwarded from the staged write |
| rdb_data | output | 256 | Read port B value, forwarded from the staged write |
| wr_valid | output | 1 | A staged result is being written this cycle |
| wr_idx | output | 4 | Index of the staged result |
| fault | output | 1 | Reserved form code seen in the previous cycle |

## Verification
The commit of one result into the file and the source read of the next operation fall in the same cycle when two dependent operations issue back to back, so the forwarding path and the write port act together. The bench provokes this with chains of consecutive operations where each reads the register the previous one wrote, in all three forms, and judges the outcome by comparing every read port value against its own arithmetic model after each step and by scanning all registers at the end. A reserved code issued right after a valid operation also puts a commit and a fault in adjacent cycles, checked for no stray write.

// File: rtl/simd_xor_pkg.sv
package simd_xor_pkg;

    typedef enum logic [1:0] {
        FORM_LEG128 = 2'b00,
        FORM_V128   = 2'b01,
        FORM_V256   = 2'b10,
        FORM_RSVD   = 2'b11
    } xor_form_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_COMMIT = 2'b01,
        ST_FAULT  = 2'b10
    } wr_state_e;

endpackage

// File: rtl/xorv_regfile.sv
module xorv_regfile #(
    parameter int NREG = 16,
    parameter int VW   = 256,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IDXW-1:0] waddr,
    input  logic [VW-1:0]   wdata,
    input  logic [IDXW-1:0] ra_idx,
    input  logic [IDXW-1:0] rb_idx,
    output logic [VW-1:0]   ra_data,
    output logic [VW-1:0]   rb_data
);

    logic [VW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];

endmodule

// File: rtl/xorv_alu.sv
module xorv_alu
    import simd_xor_pkg::*;
#(
    parameter int VW   = 256,
    parameter int LANE = 128,
    localparam int NLANE = VW / LANE
) (
    input  xor_form_e       form,
    input  logic            use_mem,
    input  logic [VW-1:0]   mem_data,
    input  logic [VW-1:0]   opa,
    input  logic [VW-1:0]   opb,
    output logic [VW-1:0]   result
);

    logic [VW-1:0] opb_sel;
    logic [VW-1:0] x;

    assign opb_sel = use_mem ? mem_data : opb;
    assign x       = opa ^ opb_sel;

    // lowest lane: every valid form writes the XOR
    assign result[LANE-1:0] = (form == FORM_RSVD) ? '0 : x[LANE-1:0];

    // upper lanes: treatment depends on the form
    for (genvar g = 1; g < NLANE; g++) begin : g_upper
        always_comb begin
            unique case (form)
                FORM_LEG128: result[g*LANE +: LANE] = opa[g*LANE +: LANE];
                FORM_V128:   result[g*LANE +: LANE] = '0;
                FORM_V256:   result[g*LANE +: LANE] = x[g*LANE +: LANE];
                default:     result[g*LANE +: LANE] = '0;
            endcase
        end
    end

endmodule

// File: rtl/xorv_ctrl.sv
module xorv_ctrl
    import simd_xor_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      op_valid,
    input  xor_form_e form,
    output logic      capture,
    output logic      wr_valid,
    output logic      fault
);

    wr_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_COMMIT, ST_FAULT: begin
                if (op_valid && form == FORM_RSVD) begin
                    state_nx = ST_FAULT;
                end else if (op_valid) begin
                    state_nx = ST_COMMIT;
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_valid = 1'b0;
        fault    = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_COMMIT: wr_valid = 1'b1;
            ST_FAULT:  fault    = 1'b1;
            default:   ;
        endcase
    end

    assign capture = op_valid && (form != FORM_RSVD);

endmodule

// File: rtl/simd_xor_wpath.sv
module simd_xor_wpath
    import simd_xor_pkg::*;
#(
    parameter int NREG = 16,
    parameter int VW   = 256,
    parameter int LANE = 128,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [1:0]      op_form,
    input  logic            long_mode,
    input  logic [IDXW-1:0] dst_idx,
    input  logic [IDXW-1:0] src1_idx,
    input  logic [IDXW-1:0] src2_idx,
    input  logic            use_mem,
    input  logic [VW-1:0]   mem_data,
    output logic [VW-1:0]   rda_data,
    output logic [VW-1:0]   rdb_data,
    output logic            wr_valid,
    output logic [IDXW-1:0] wr_idx,
    output logic            fault
);

    xor_form_e       form;
    logic            narrow_idx;
    logic [IDXW-1:0] dst_e;
    logic [IDXW-1:0] src2_e;
    logic [IDXW-1:0] ra_idx;
    logic            capture;
    logic [VW-1:0]   rf_a;
    logic [VW-1:0]   rf_b;
    logic [VW-1:0]   result;
    logic [IDXW-1:0] stg_idx;
    logic [VW-1:0]   stg_data;

    assign form       = xor_form_e'(op_form);
    assign narrow_idx = (form == FORM_LEG128) && !long_mode;
    assign dst_e      = narrow_idx ? {1'b0, dst_idx[IDXW-2:0]}  : dst_idx;
    assign src2_e     = narrow_idx ? {1'b0, src2_idx[IDXW-2:0]} : src2_idx;
    assign ra_idx     = (form == FORM_LEG128) ? dst_e : src1_idx;

    xorv_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .form     (form),
        .capture  (capture),
        .wr_valid (wr_valid),
        .fault    (fault)
    );

    xorv_regfile #(.NREG(NREG), .VW(VW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_valid),
        .waddr   (stg_idx),
        .wdata   (stg_data),
        .ra_idx  (ra_idx),
        .rb_idx  (src2_e),
        .ra_data (rf_a),
        .rb_data (rf_b)
    );

    // forwarding of the staged result onto both read ports
    assign rda_data = (wr_valid && stg_idx == ra_idx) ? stg_data : rf_a;
    assign rdb_data = (wr_valid && stg_idx == src2_e) ? stg_data : rf_b;

    xorv_alu #(.VW(VW), .LANE(LANE)) u_alu (
        .form     (form),
        .use_mem  (use_mem),
        .mem_data (mem_data),
        .opa      (rda_data),
        .opb      (rdb_data),
        .result   (result)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_idx  <= '0;
            stg_data <= '0;
        end else if (capture) begin
            stg_idx  <= dst_e;
            stg_data <= result;
        end
    end

    assign wr_idx = stg_idx;

endmodule

// File: rtl/simd_xor_wpath_chk.sv
module simd_xor_wpath_chk #(
    parameter int VW   = 256,
    parameter int LANE = 128,
    parameter int IDXW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [1:0]      op_form,
    input logic            long_mode,
    input logic [IDXW-1:0] dst_idx,
    input logic            use_mem,
    input logic [VW-1:0]   mem_data,
    input logic [VW-1:0]   rda_data,
    input logic [VW-1:0]   rdb_data,
    input logic            wr_valid,
    input logic [IDXW-1:0] wr_idx,
    input logic            fault,
    input logic [VW-1:0]   stg_data
);

    logic [IDXW-1:0] want_idx;
    logic            good_op;

    assign want_idx = (op_form == 2'b00 && !long_mode) ? {1'b0, dst_idx[IDXW-2:0]} : dst_idx;
    assign good_op  = op_valid && (op_form != 2'b11);

    // R6
    wr_after_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        good_op |=> wr_valid);

    // R5
    wr_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        good_op |=> (wr_idx == $past(want_idx)));

    // R8
    rsvd_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_form == 2'b11) |=> (fault && !wr_valid));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!wr_valid && !fault));

    // R1
    wide_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_form == 2'b10) |=>
            (stg_data == $past(rda_data ^ (use_mem ? mem_data : rdb_data))));

    // R2
    narrow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_form == 2'b01) |=> (stg_data[VW-1:LANE] == '0));

    // R3
    legacy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_form == 2'b00) |=>
            (stg_data[VW-1:LANE] == $past(rda_data[VW-1:LANE])));

    // R8
    excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && fault));

endmodule

bind simd_xor_wpath simd_xor_wpath_chk #(.VW(VW), .LANE(LANE), .IDXW(IDXW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_form   (op_form),
    .long_mode (long_mode),
    .dst_idx   (dst_idx),
    .use_mem   (use_mem),
    .mem_data  (mem_data),
    .rda_data  (rda_data),
    .rdb_data  (rdb_data),
    .wr_valid  (wr_valid),
    .wr_idx    (wr_idx),
    .fault     (fault),
    .stg_data  (stg_data)
);

// File: tb/simd_xor_wpath_test.sv
`timescale 1ns/1ps
module simd_xor_wpath_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [1:0]   op_form = 2'b10;
    logic         long_mode = 1'b1;
    logic [3:0]   dst_idx = '0;
    logic [3:0]   src1_idx = '0;
    logic [3:0]   src2_idx = '0;
    logic         use_mem = 1'b0;
    logic [255:0] mem_data = '0;
    logic [255:0] rda_data, rdb_data;
    logic         wr_valid, fault;
    logic [3:0]   wr_idx;

    int checks = 0;
    int errors = 0;
    logic [255:0] mdl [16];

    always #4 clk = ~clk;

    simd_xor_wpath uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_form(op_form),
        .long_mode(long_mode), .dst_idx(dst_idx), .src1_idx(src1_idx),
        .src2_idx(src2_idx), .use_mem(use_mem), .mem_data(mem_data),
        .rda_data(rda_data), .rdb_data(rdb_data), .wr_valid(wr_valid),
        .wr_idx(wr_idx), .fault(fault)
    );

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] eidx(input logic [1:0] f, input logic lm, input logic [3:0] i);
        return (f == 2'b00 && !lm) ? {1'b0, i[2:0]} : i;
    endfunction

    function automatic logic [255:0] pat(input int i);
        logic [63:0] a = 64'h9E3779B97F4A7C15 * 64'(i + 1);
        logic [63:0] b = 64'hC2B2AE3D27D4EB4F * 64'(i + 7);
        return {b, a ^ b, ~a, a};
    endfunction

    // drive one operation (caller stands just after a falling edge) and update the model
    task automatic issue(input logic [1:0] f, input logic lm, input logic [3:0] d,
                         input logic [3:0] s1, input logic [3:0] s2, input logic um,
                         input logic [255:0] mem);
        logic [255:0] a, b, x, r;
        op_valid = 1'b1; op_form = f; long_mode = lm; dst_idx = d;
        src1_idx = s1; src2_idx = s2; use_mem = um; mem_data = mem;
        a = (f == 2'b00) ? mdl[eidx(f, lm, d)] : mdl[s1];
        b = um ? mem : mdl[eidx(f, lm, s2)];
        x = a ^ b;
        case (f)
            2'b00:   r = {a[255:128], x[127:0]};
            2'b01:   r = {128'b0, x[127:0]};
            default: r = x;
        endcase
        if (f != 2'b11) mdl[eidx(f, lm, d)] = r;
    endtask

    task automatic scan(input string tag);
        op_valid = 1'b0; op_form = 2'b10;
        for (int i = 0; i < 16; i++) begin
            src2_idx = 4'(i);
            #1;
            chk(rdb_data === mdl[i], tag, rdb_data, mdl[i]);
        end
    endtask

    task automatic peek_a(input logic [3:0] i, input string tag);
        op_valid = 1'b0; op_form = 2'b10; src1_idx = i;
        #1;
        chk(rda_data === mdl[i], tag, rda_data, mdl[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R6 act=%0d exp=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        string tg;
        logic [3:0] ed;
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(wr_valid === 1'b0, "R9 wr_valid", 256'(wr_valid), 256'(0));
        chk(fault === 1'b0, "R9 fault", 256'(fault), 256'(0));
        scan("R9 reg clear");

        // load distinct patterns back to back (wide form, memory operand)
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            issue(2'b10, 1'b1, 4'(i), 4'(i), 4'(0), 1'b1, pat(i) ^ mdl[i]);
        end
        @(negedge clk);
        scan("R4 load");

        // sweep: form x memory select x long mode x destination
        for (int f = 0; f < 3; f++) begin
            for (int um = 0; um < 2; um++) begin
                for (int lm = 0; lm < 2; lm++) begin
                    for (int d = 0; d < 16; d++) begin
                        @(negedge clk);
                        issue(2'(f), lm[0], 4'(d), 4'((d + 5) % 16), 4'((d + 11) % 16),
                              um[0], pat(d + 40) ^ {8{32'(f * 7 + lm)}});
                        ed = eidx(2'(f), lm[0], 4'(d));
                        tg = (f == 0) ? "R3" : (f == 1) ? "R2" : "R1";
                        if (um == 1) tg = {tg, "/R4"};
                        if (f == 0) tg = {tg, "/R5"};
                        @(negedge clk);
                        chk(wr_valid === 1'b1, "R6 wr_valid", 256'(wr_valid), 256'(1));
                        chk(wr_idx === ed, "R6/R5 wr_idx", 256'(wr_idx), 256'(ed));
                        peek_a(ed, {tg, " R7 forwarded"});
                        @(negedge clk);
                        peek_a(ed, {tg, " held"});
                    end
                    scan("R5 sweep scan");
                end
            end
        end

        // dependent chain: each op reads the register the previous one wrote
        @(negedge clk); issue(2'b10, 1'b1, 4'd3, 4'd4, 4'd5, 1'b0, '0);
        @(negedge clk); issue(2'b10, 1'b1, 4'd6, 4'd3, 4'd7, 1'b0, '0);
        @(negedge clk); issue(2'b00, 1'b1, 4'd6, 4'd0, 4'd3, 1'b0, '0);
        @(negedge clk); issue(2'b01, 1'b1, 4'd9, 4'd6, 4'd6, 1'b1, pat(77));
        @(negedge clk); issue(2'b00, 1'b0, 4'd9, 4'd0, 4'd9, 1'b0, '0);
        @(negedge clk); issue(2'b10, 1'b1, 4'd1, 4'd1, 4'd1, 1'b0, '0);
        @(negedge clk);
        chk(wr_idx === 4'd1, "R7 chain wr_idx", 256'(wr_idx), 256'(1));
        peek_a(4'd1, "R1 self xor zero");
        scan("R7 chain scan");

        // reserved form right after a valid op
        @(negedge clk); issue(2'b10, 1'b1, 4'd2, 4'd8, 4'd10, 1'b0, '0);
        @(negedge clk); issue(2'b11, 1'b1, 4'd2, 4'd8, 4'd10, 1'b1, {256{1'b1}});
        @(negedge clk);
        op_valid = 1'b0;
        chk(fault === 1'b1, "R8 fault", 256'(fault), 256'(1));
        chk(wr_valid === 1'b0, "R8 no write", 256'(wr_valid), 256'(0));
        for (int d = 0; d < 16; d++) begin
            @(negedge clk); issue(2'b11, 1'b1, 4'(d), 4'(d), 4'(d), 1'b1, pat(d));
            @(negedge clk);
            op_valid = 1'b0;
            chk(fault === 1'b1 && wr_valid === 1'b0, "R8 sweep", 256'({fault, wr_valid}), 256'(2));
        end
        scan("R8 no change");

        // idle cycles with busy inputs
        @(negedge clk);
        op_valid = 1'b0; op_form = 2'b10; dst_idx = 4'd5; use_mem = 1'b1; mem_data = pat(3);
        @(negedge clk);
        chk(wr_valid === 1'b0 && fault === 1'b0, "R10 idle", 256'({wr_valid, fault}), 256'(0));
        scan("R10 no change");

        // reset after activity
        @(negedge clk); issue(2'b10, 1'b1, 4'd12, 4'd13, 4'd14, 1'b0, '0);
        rst_n = 1'b0;
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        chk(wr_valid === 1'b0 && fault === 1'b0, "R9 flags", 256'({wr_valid, fault}), 256'(0));
        scan("R9 clear");
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule